// File: doc/BRIEF.md
# Receive Word Output and Byte-Clock Generator

This block sits after a deserializer and comma aligner. It places aligned 10-bit code groups on a parallel receive bus and produces the receive byte clocks that a downstream device uses to capture that bus. The block runs on an internal clock at the serial bit rate, so each bit time is one cycle of `clk`. A word lasts `WORD_BITS` cycles. Both byte clocks are registered outputs that toggle at fixed bit times inside each word.

Two static select inputs choose one of three interface modes:
- a 10-bit bus with two interleaved half-rate byte clocks;
- a 10-bit bus with one word-rate byte clock;
- a 5-bit double-data-rate bus with one word-rate byte clock.

A realign pulse from the comma detector moves the word boundary later by a given number of bit times. While that happens the block freezes its phase and every output. As a result, a clock phase can only become longer, never shorter.

Below, "bit time p" means the p-th cycle of a word: p = 0 is the cycle in which a newly captured word first appears on `rx_data_o`, and with the default parameters p runs from 0 to 9. Word indices count from 0, starting with the first word captured after reset.

Top module: `rx_byteclk_out`

## Requirements
- R1: A synchronous active-high `rst` drives `bclk0_o` and `bclk1_o` low and clears `rx_data_o` to zero. After reset, the first word is captured on the first clock edge with `rst` low. In half-rate mode the first rising clock edge after reset is on `bclk1_o`, at bit time 5 of word 0.
- R2: With `sel_ddr_i` low (10-bit bus), `code_i` is captured at each word boundary. It appears unchanged on all ten bits of `rx_data_o` at bit time 0 and is held for a full word.
- R3: Half-rate mode is selected by `sel_ddr_i` low and `sel_word_clk_i` low. At bit time 5 of each word, `bclk1_o` goes high and `bclk0_o` goes low when the word index is even (words 0 and 2 of each group of four). The opposite happens when the index is odd (words 1 and 3). Each clock is therefore high for one word and low for one word.
- R4: Word-clock mode is selected by `sel_ddr_i` low and `sel_word_clk_i` high. `bclk0_o` is high during bit times 5 to 9 and low during bit times 0 to 4. `bclk1_o` stays low.
- R5: With `sel_ddr_i` high, `sel_word_clk_i` has no effect. `bclk0_o` follows the R4 pattern and `bclk1_o` stays low.
- R6: In double-data-rate mode, `rx_data_o[4:0]` carries word bits 4:0 from bit time 3 through bit time 7. This window is centred on the rising edge of `bclk0_o`. `rx_data_o[4:0]` then carries word bits 9:5 from bit time 8 through bit time 2 of the next word, centred on the falling edge. `rx_data_o[9:5]` is driven low.
- R7: When `realign_i` is high with `slip_i` = s, where s is not zero, the bit-time phase and all outputs hold for s cycles, starting with that edge. This moves the next word capture s cycles later. A realign pulse with `slip_i` = 0 has no effect. A realign pulse that arrives while a hold is in progress is ignored.
- R8: While the mode inputs stay constant, no high or low phase of `bclk0_o` is shorter than its nominal width. The nominal width is 10 cycles in half-rate mode and 5 cycles in the other modes.
- R9: In half-rate mode, once either clock has risen after reset, `bclk0_o` and `bclk1_o` are always complementary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_ddr_i | input | 1 | 1 selects the 5-bit double-data-rate bus; 0 selects the 10-bit bus |
| sel_word_clk_i | input | 1 | With the 10-bit bus: 1 selects a single word-rate clock, 0 selects the half-rate pair |
| code_i | input | WORD_BITS (10) | Aligned code group from the deserializer |
| realign_i | input | 1 | Boundary realign request from the comma detector |
| slip_i | input | SLIP_BITS (4) | Number of bit times the boundary moves later |
| rx_data_o | output | WORD_BITS (10) | Parallel receive bus |
| bclk0_o | output | 1 | Byte clock 0 |
| bclk1_o | output | 1 | Byte clock 1; stays low outside half-rate mode |

## Verification
The assertions check the following on every cycle:
- all three outputs stay frozen during a realign hold;
- the minimum width of every `bclk0_o` phase;
- the complementary relationship of the half-rate pair;
- `bclk1_o` staying low outside half-rate mode;
- the upper bus lines staying low in double-data-rate mode;
- the phase range and the stepping of the word index.

Several properties depend on the sequence of stimulus and can only be shown by the bench scenarios:
- which word index drives which clock;
- the exact bit times at which the data and clocks change in each mode;
- the delayed word capture after a slip;
- a zero slip having no effect;
- a second realign being ignored during a hold.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    typedef enum logic [1:0] {
        MODE_HALF = 2'd0,
        MODE_WORD = 2'd1,
        MODE_DDR  = 2'd2
    } rxo_mode_e;

    // The DDR select dominates; the clock-rate select only matters on the 10-bit bus.
    function automatic rxo_mode_e rxo_decode(input logic ddr, input logic word_clk);
        if (ddr)           return MODE_DDR;
        else if (word_clk) return MODE_WORD;
        else               return MODE_HALF;
    endfunction

endpackage

// File: rtl/rxo_phase.sv
module rxo_phase #(
    parameter int WORD_BITS = 10,
    parameter int SLIP_BITS = 4,
    localparam int PH_W = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 realign_i,
    input  logic [SLIP_BITS-1:0] slip_i,
    output logic [PH_W-1:0]      ph_nxt_o,
    output logic                 adv_o,
    output logic                 word_odd_o
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_BITS - 1);

    typedef struct packed {
        logic [PH_W-1:0]      ph;
        logic [1:0]           widx;
        logic [SLIP_BITS-1:0] hold;
    } phase_t;

    phase_t s_d, s_q;
    logic   take;
    logic   adv;

    always_comb begin
        s_d  = s_q;
        take = realign_i && (slip_i != '0) && (s_q.hold == '0);
        adv  = !take && (s_q.hold == '0);
        if (take)
            s_d.hold = slip_i - 1'b1;
        else if (s_q.hold != '0)
            s_d.hold = s_q.hold - 1'b1;
        if (adv) begin
            if (s_q.ph == PH_LAST) begin
                s_d.ph   = '0;
                s_d.widx = s_q.widx + 2'd1;
            end else begin
                s_d.ph = s_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph   <= PH_LAST;
            s_q.widx <= 2'd3;
            s_q.hold <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ph_nxt_o   = s_d.ph;
    assign adv_o      = adv;
    assign word_odd_o = s_q.widx[0];

    // R2: the bit-time phase never leaves the word
    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        s_q.ph <= PH_LAST);

    // R3: word index steps by one at each boundary crossing
    a_r3_widx_steps: assert property (@(posedge clk) disable iff (rst)
        (adv && s_q.ph == PH_LAST) |=> (s_q.widx == $past(s_q.widx) + 2'd1));

    // R7: a hold in progress blocks phase advance
    a_r7_phase_frozen: assert property (@(posedge clk) disable iff (rst)
        (s_q.hold != '0) |=> $stable(s_q.ph));
endmodule

// File: rtl/rxo_clkgen.sv
module rxo_clkgen
    import rxo_pkg::*;
#(
    parameter int WORD_BITS = 10,
    localparam int PH_W = $clog2(WORD_BITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  rxo_mode_e       mode_i,
    input  logic            adv_i,
    input  logic [PH_W-1:0] ph_nxt_i,
    input  logic            word_odd_i,
    output logic            bclk0_o,
    output logic            bclk1_o
);
    localparam logic [PH_W-1:0] PH_MID = PH_W'(WORD_BITS / 2);

    typedef struct packed {
        logic b0;
        logic b1;
    } clk_t;

    clk_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (adv_i) begin
            if (mode_i == MODE_HALF) begin
                if (ph_nxt_i == PH_MID) begin
                    c_d.b1 = !word_odd_i;
                    c_d.b0 = word_odd_i;
                end
            end else begin
                c_d.b1 = 1'b0;
                if (ph_nxt_i == PH_MID)
                    c_d.b0 = 1'b1;
                else if (ph_nxt_i == '0)
                    c_d.b0 = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign bclk0_o = c_q.b0;
    assign bclk1_o = c_q.b1;

    // R9: half-rate pair stays complementary once started
    a_r9_pair_opposite: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_HALF && $past(mode_i) == MODE_HALF && (c_q.b0 || c_q.b1))
        |-> (c_q.b0 != c_q.b1));

    // R4 / R5: second clock low outside half-rate mode
    a_r4_bclk1_low: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) != MODE_HALF && $past(adv_i)) |-> !c_q.b1);
endmodule

// File: rtl/rxo_dataout.sv
module rxo_dataout
    import rxo_pkg::*;
#(
    parameter int WORD_BITS = 10,
    localparam int PH_W = $clog2(WORD_BITS),
    localparam int HALF = WORD_BITS / 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rxo_mode_e            mode_i,
    input  logic                 adv_i,
    input  logic [PH_W-1:0]      ph_nxt_i,
    input  logic [WORD_BITS-1:0] code_i,
    output logic [WORD_BITS-1:0] rx_data_o
);
    localparam logic [PH_W-1:0] PH_LO = PH_W'(HALF - HALF / 2);
    localparam logic [PH_W-1:0] PH_HI = PH_W'(WORD_BITS - HALF / 2);

    typedef struct packed {
        logic [WORD_BITS-1:0] hold;
        logic [WORD_BITS-1:0] rd;
    } dout_t;

    dout_t d_d, d_q;
    logic [WORD_BITS-1:0] lo_ext, hi_ext;

    assign lo_ext = {{(WORD_BITS-HALF){1'b0}}, d_q.hold[HALF-1:0]};
    assign hi_ext = {{(WORD_BITS-HALF){1'b0}}, d_q.hold[WORD_BITS-1:HALF]};

    always_comb begin
        d_d = d_q;
        if (adv_i) begin
            if (ph_nxt_i == '0) begin
                d_d.hold = code_i;
                if (mode_i != MODE_DDR)
                    d_d.rd = code_i;
            end
            if (mode_i == MODE_DDR) begin
                if (ph_nxt_i == PH_LO)
                    d_d.rd = lo_ext;
                else if (ph_nxt_i == PH_HI)
                    d_d.rd = hi_ext;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) d_q <= '0;
        else     d_q <= d_d;
    end

    assign rx_data_o = d_q.rd;

    // R6: upper lines low whenever the DDR bus updates
    a_r6_upper_low: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == MODE_DDR && !$stable(d_q.rd))
        |-> (d_q.rd[WORD_BITS-1:HALF] == '0));
endmodule

// File: rtl/rx_byteclk_out.sv
module rx_byteclk_out
    import rxo_pkg::*;
#(
    parameter int WORD_BITS = 10,
    parameter int SLIP_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_ddr_i,
    input  logic                 sel_word_clk_i,
    input  logic [WORD_BITS-1:0] code_i,
    input  logic                 realign_i,
    input  logic [SLIP_BITS-1:0] slip_i,
    output logic [WORD_BITS-1:0] rx_data_o,
    output logic                 bclk0_o,
    output logic                 bclk1_o
);
    localparam int PH_W  = $clog2(WORD_BITS);
    localparam int CNT_W = PH_W + 2;

    rxo_mode_e       mode;
    logic [PH_W-1:0] ph_nxt;
    logic            adv;
    logic            word_odd;

    assign mode = rxo_decode(sel_ddr_i, sel_word_clk_i);

    rxo_phase #(.WORD_BITS(WORD_BITS), .SLIP_BITS(SLIP_BITS)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .realign_i  (realign_i),
        .slip_i     (slip_i),
        .ph_nxt_o   (ph_nxt),
        .adv_o      (adv),
        .word_odd_o (word_odd)
    );

    rxo_clkgen #(.WORD_BITS(WORD_BITS)) u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .adv_i      (adv),
        .ph_nxt_i   (ph_nxt),
        .word_odd_i (word_odd),
        .bclk0_o    (bclk0_o),
        .bclk1_o    (bclk1_o)
    );

    rxo_dataout #(.WORD_BITS(WORD_BITS)) u_dataout (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .adv_i     (adv),
        .ph_nxt_i  (ph_nxt),
        .code_i    (code_i),
        .rx_data_o (rx_data_o)
    );

    // Checker state: duration of the current bclk0 level under a constant mode
    logic [CNT_W-1:0] run_q;
    logic             prev_b0_q;
    logic             seen_q;
    rxo_mode_e        mode_prev_q;
    logic [CNT_W-1:0] nominal;

    assign nominal = (mode == MODE_HALF) ? CNT_W'(WORD_BITS) : CNT_W'(WORD_BITS / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= '0;
            prev_b0_q   <= 1'b0;
            seen_q      <= 1'b0;
            mode_prev_q <= MODE_HALF;
        end else begin
            prev_b0_q   <= bclk0_o;
            mode_prev_q <= mode;
            if (bclk0_o != prev_b0_q)
                run_q <= CNT_W'(1);
            else if (run_q != '1)
                run_q <= run_q + 1'b1;
            if (mode != mode_prev_q)
                seen_q <= 1'b0;
            else if (bclk0_o != prev_b0_q)
                seen_q <= 1'b1;
        end
    end

    // R8: no bclk0 phase shorter than nominal
    a_r8_min_width: assert property (@(posedge clk) disable iff (rst)
        (bclk0_o != prev_b0_q && seen_q && mode == mode_prev_q) |-> (run_q >= nominal));

    // R7: every output frozen while the phase holds
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(bclk0_o) && $stable(bclk1_o) && $stable(rx_data_o)));

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (!bclk0_o && !bclk1_o && rx_data_o == '0));
endmodule

// File: tb/rx_byteclk_out_bench.sv
`timescale 1ns/1ps
module rx_byteclk_out_bench;
    localparam int W  = 10;
    localparam int NW = 8;
    localparam int NV = 5;
    // {ddr, word_clk, base word}
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b0, 10'h155},
        {1'b0, 1'b0, 10'h0F3},
        {1'b0, 1'b1, 10'h2A9},
        {1'b1, 1'b0, 10'h36C},
        {1'b1, 1'b1, 10'h1B7}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_ddr_i = 1'b0;
    logic       sel_word_clk_i = 1'b0;
    logic [9:0] code_i = '0;
    logic       realign_i = 1'b0;
    logic [3:0] slip_i = '0;
    logic [9:0] rx_data_o;
    logic       bclk0_o, bclk1_o;

    int total = 0;
    int failed = 0;

    always #2.5 clk = ~clk;

    rx_byteclk_out u_rx_byteclk_out (
        .clk(clk), .rst(rst), .sel_ddr_i(sel_ddr_i), .sel_word_clk_i(sel_word_clk_i),
        .code_i(code_i), .realign_i(realign_i), .slip_i(slip_i),
        .rx_data_o(rx_data_o), .bclk0_o(bclk0_o), .bclk1_o(bclk1_o)
    );

    function automatic logic [9:0] word_of(input logic [9:0] base, input int m);
        return base + 10'(m * 73);
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    task automatic do_reset(input logic ddr, input logic wclk);
        @(negedge clk);
        rst = 1'b1; realign_i = 1'b0; slip_i = '0;
        sel_ddr_i = ddr; sel_word_clk_i = wclk;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", {bclk1_o, bclk0_o, rx_data_o}, 12'h000);
    endtask

    initial begin
        #(5.0 * 150000);
        failed++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Table-driven walk over modes
        for (int v = 0; v < NV; v++) begin
            logic ddr, wclk;
            logic [9:0] base;
            ddr = VEC[v][11]; wclk = VEC[v][10]; base = VEC[v][9:0];
            do_reset(ddr, wclk);
            for (int n = 1; n <= NW * W; n++) begin
                int m, p;
                logic eb0, eb1;
                logic [9:0] ed, w, pw;
                m = (n - 1) / W; p = (n - 1) % W;
                code_i = word_of(base, m);
                @(posedge clk);
                @(negedge clk);
                w  = word_of(base, m);
                pw = (m == 0) ? 10'h000 : word_of(base, m - 1);
                if (ddr) begin
                    eb0 = (p >= 5); eb1 = 1'b0;
                    if (p >= 3 && p <= 7)      ed = {5'b0, w[4:0]};
                    else if (p >= 8)           ed = {5'b0, w[9:5]};
                    else if (m == 0)           ed = 10'h000;
                    else                       ed = {5'b0, pw[9:5]};
                    chk("R5 ddr clocks", {2'b00, eb1, eb0, 8'h00}, {2'b00, bclk1_o, bclk0_o, 8'h00});
                    chk("R6 ddr data", {2'b00, rx_data_o}, {2'b00, ed});
                end else begin
                    ed = w;
                    if (wclk) begin
                        eb0 = (p >= 5); eb1 = 1'b0;
                        chk("R4 word clock", {10'h000, bclk1_o, bclk0_o}, {10'h000, eb1, eb0});
                    end else begin
                        if (p >= 5)      begin eb1 = (m % 2 == 0); eb0 = (m % 2 == 1); end
                        else if (m == 0) begin eb1 = 1'b0; eb0 = 1'b0; end
                        else             begin eb1 = ((m - 1) % 2 == 0); eb0 = ((m - 1) % 2 == 1); end
                        chk((m == 0) ? "R1 first edge on bclk1" : "R3 half-rate pair",
                            {10'h000, bclk1_o, bclk0_o}, {10'h000, eb1, eb0});
                    end
                    chk("R2 word bus", {2'b00, rx_data_o}, {2'b00, ed});
                end
            end
        end

        // Directed: realign stretching in half-rate mode
        do_reset(1'b0, 1'b0);
        for (int n = 1; n <= 52; n++) begin
            code_i    = (n <= 30) ? 10'h0A5 : 10'h35A;
            realign_i = (n == 28 || n == 30 || n == 45);
            slip_i    = (n == 28) ? 4'd3 : (n == 30) ? 4'd5 : 4'd0;
            @(posedge clk);
            @(negedge clk);
            if (n == 33) chk("R7 capture delayed", {2'b00, rx_data_o}, {2'b00, 10'h0A5});
            if (n == 34) chk("R7 capture after slip", {2'b00, rx_data_o}, {2'b00, 10'h35A});
            if (n == 29) chk("R7 outputs held", {10'h000, bclk1_o, bclk0_o}, 12'h002);
            if (n == 38) chk("R8 bclk1 stretched high", {10'h000, bclk1_o, bclk0_o}, 12'h002);
            if (n == 39) chk("R9 pair swaps after stretch", {10'h000, bclk1_o, bclk0_o}, 12'h001);
            if (n == 48) chk("R7 zero slip no effect", {10'h000, bclk1_o, bclk0_o}, 12'h001);
            if (n == 49) chk("R7 zero slip keeps timing", {10'h000, bclk1_o, bclk0_o}, 12'h002);
        end
        realign_i = 1'b0;
        finish_run();
    end
endmodule